// File: doc/BRIEF.md
# Bus-Cycle Address Strobe and DMA Stall Controller

This block models the motherboard logic beside an eight-bit processor that reports its bus activity on three status lines. It turns those lines into an address-latch strobe that marks each new bus cycle. It also turns the same lines into enables for memory and I/O read and write commands. When a DMA or refresh request arrives, the block does not use a hold/acknowledge exchange with the processor. It waits for a status value that is safe for a grant, gives the bus to the DMA controller, raises the address-enable line and holds the processor in wait states through its ready input until the DMA controller reports that it has finished.

The address-enable line gates only the command enables. The strobe comes straight from the status lines and address-enable has no effect on it. If the processor still starts a cycle after the grant, the strobe pulses while address-enable is high. Cards that latch the address on that strobe would then capture the DMA address. The block keeps these stray strobes on purpose, so that the effect can be reproduced. A parameter picks the grant rule. The original rule grants only when the status is passive. The later rule also grants when the status shows a halt.

Top module: `cpu_bus_pause`

## Requirements
- R1: While reset is held and right after it is released, `ale_o`=0, `ready_o`=1, `aen_o`=0 and `dma_grant_o`=0.
- R2: When `status_i` is sampled as a non-passive value on a clock edge and the value sampled on the previous edge was passive (3'b111), `ale_o` is high for exactly the one cycle after that edge.
- R3: A change from one non-passive value to another, a change back to passive, or a steady status causes no `ale_o` pulse.
- R4: With `LATER_MODE`=0, a pending `dma_req_i` is granted only on an edge where `status_i` is 3'b111. Under any other status it stays pending and `dma_grant_o` stays 0.
- R5: With `LATER_MODE`=1, a grant is also given when `status_i[1:0]`=2'b11 (halt 3'b011 or passive). In the same conditions, `LATER_MODE`=0 gives no grant on 3'b011.
- R6: `dma_grant_o` and `aen_o` rise on the edge that grants. `ready_o` falls one clock later and stays low while the grant lasts.
- R7: `dma_grant_o` falls on the edge that samples `dma_done_i`. On the next edge `ready_o` rises and `aen_o` falls together.
- R8: While `aen_o` is high, every command enable is 0. `ale_o` is still produced, so a passive-to-active status change during the grant pulses `ale_o` with `aen_o` high.
- R9: With `aen_o` low, the command enables decode `status_i` combinationally: 3'b100 and 3'b101 give memory read, 3'b110 gives memory write, 3'b001 gives I/O read and 3'b010 gives I/O write. Codes 3'b000, 3'b011 and 3'b111 enable nothing.
- R10: `dma_done_i` has no effect when no grant is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| status_i | input | 3 | Processor bus status, 3'b111 passive |
| dma_req_i | input | 1 | DMA or refresh request |
| dma_done_i | input | 1 | DMA controller has finished its cycle |
| ale_o | output | 1 | Address-latch strobe, one cycle per new bus cycle |
| ready_o | output | 1 | Processor ready, low inserts wait states |
| aen_o | output | 1 | Address enable, high while DMA owns the bus |
| dma_grant_o | output | 1 | Bus granted to the DMA controller |
| mem_rd_en_o | output | 1 | Memory read command enable |
| mem_wr_en_o | output | 1 | Memory write command enable |
| io_rd_en_o | output | 1 | I/O read command enable |
| io_wr_en_o | output | 1 | I/O write command enable |

## Verification
The hardest case to reach is the stray strobe. A grant has to have taken place, the status has to be passive, and then the processor has to start a new cycle before the DMA controller finishes. The bench grants on a passive status and keeps `dma_done_i` low. It then moves the status to a memory fetch code and checks that `ale_o` is high while `aen_o` is high and all command enables are held off. Both grant rules run side by side on shared stimulus, so a halt status can be shown to be refused by one instance and granted by the other in the same cycle.

// File: rtl/bus_pause_pkg.sv
package bus_pause_pkg;
  localparam int unsigned STAT_W = 3;
  typedef logic [STAT_W-1:0] stat_t;

  localparam stat_t ST_INTA  = 3'b000;
  localparam stat_t ST_IORD  = 3'b001;
  localparam stat_t ST_IOWR  = 3'b010;
  localparam stat_t ST_HALT  = 3'b011;
  localparam stat_t ST_FETCH = 3'b100;
  localparam stat_t ST_MEMRD = 3'b101;
  localparam stat_t ST_MEMWR = 3'b110;
  localparam stat_t ST_IDLE  = 3'b111;

  typedef enum logic [1:0] {
    PS_FREE,
    PS_OWNED,
    PS_RETURN
  } pause_state_e;

  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic io_rd;
    logic io_wr;
  } cmd_en_t;
endpackage

// File: rtl/ale_pulse_gen.sv
module ale_pulse_gen
  import bus_pause_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  stat_t status_i,
  output logic  ale_o
);
  stat_t prev_q;
  logic  ale_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= ST_IDLE;
      ale_q  <= 1'b0;
    end else begin
      prev_q <= status_i;
      ale_q  <= (prev_q == ST_IDLE) && (status_i != ST_IDLE);
    end
  end

  assign ale_o = ale_q;

  // R2
  ale_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_q |=> !ale_q);
endmodule

// File: rtl/dma_stall_ctrl.sv
module dma_stall_ctrl
  import bus_pause_pkg::*;
#(
  parameter bit LATER_MODE = 1'b0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  stat_t status_i,
  input  logic  dma_req_i,
  input  logic  dma_done_i,
  output logic  grant_o,
  output logic  aen_o,
  output logic  ready_o
);
  pause_state_e state_q;
  logic grant_q, aen_q, ready_q;
  logic slot_ok;

  generate
    if (LATER_MODE) begin : g_later
      assign slot_ok = (status_i[1:0] == 2'b11);
    end else begin : g_orig
      assign slot_ok = (status_i == ST_IDLE);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_FREE;
      grant_q <= 1'b0;
      aen_q   <= 1'b0;
      ready_q <= 1'b1;
    end else begin
      unique case (state_q)
        PS_FREE: begin
          if (dma_req_i && slot_ok) begin
            state_q <= PS_OWNED;
            grant_q <= 1'b1;
            aen_q   <= 1'b1;
          end
        end
        PS_OWNED: begin
          ready_q <= 1'b0;
          if (dma_done_i) begin
            grant_q <= 1'b0;
            state_q <= PS_RETURN;
          end
        end
        PS_RETURN: begin
          ready_q <= 1'b1;
          aen_q   <= 1'b0;
          state_q <= PS_FREE;
        end
        default: state_q <= PS_FREE;
      endcase
    end
  end

  assign grant_o = grant_q;
  assign aen_o   = aen_q;
  assign ready_o = ready_q;

  // R6
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_q) |=> !ready_q);
  // R7
  aen_ready_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(aen_q) |-> $rose(ready_q));
  // R6
  grant_aen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_q |-> aen_q);

  generate
    if (LATER_MODE) begin : g_chk_later
      // R5
      grant_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(grant_q) |-> ($past(status_i[1:0]) == 2'b11));
    end else begin : g_chk_orig
      // R4
      grant_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(grant_q) |-> ($past(status_i) == ST_IDLE));
    end
  endgenerate
endmodule

// File: rtl/cmd_enable_gate.sv
module cmd_enable_gate
  import bus_pause_pkg::*;
(
  input  stat_t   status_i,
  input  logic    aen_i,
  output cmd_en_t cmd_o
);
  cmd_en_t dec;

  always_comb begin
    dec = '0;
    unique case (status_i)
      ST_FETCH, ST_MEMRD: dec.mem_rd = 1'b1;
      ST_MEMWR:           dec.mem_wr = 1'b1;
      ST_IORD:            dec.io_rd  = 1'b1;
      ST_IOWR:            dec.io_wr  = 1'b1;
      default:            dec = '0;
    endcase
    cmd_o = aen_i ? '0 : dec;
  end
endmodule

// File: rtl/cpu_bus_pause.sv
module cpu_bus_pause
  import bus_pause_pkg::*;
#(
  parameter bit LATER_MODE = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] status_i,
  input  logic       dma_req_i,
  input  logic       dma_done_i,
  output logic       ale_o,
  output logic       ready_o,
  output logic       aen_o,
  output logic       dma_grant_o,
  output logic       mem_rd_en_o,
  output logic       mem_wr_en_o,
  output logic       io_rd_en_o,
  output logic       io_wr_en_o
);
  cmd_en_t cmd;

  ale_pulse_gen u_ale (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_i),
    .ale_o    (ale_o)
  );

  dma_stall_ctrl #(.LATER_MODE(LATER_MODE)) u_stall (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .status_i   (status_i),
    .dma_req_i  (dma_req_i),
    .dma_done_i (dma_done_i),
    .grant_o    (dma_grant_o),
    .aen_o      (aen_o),
    .ready_o    (ready_o)
  );

  cmd_enable_gate u_cmd (
    .status_i (status_i),
    .aen_i    (aen_o),
    .cmd_o    (cmd)
  );

  assign mem_rd_en_o = cmd.mem_rd;
  assign mem_wr_en_o = cmd.mem_wr;
  assign io_rd_en_o  = cmd.io_rd;
  assign io_wr_en_o  = cmd.io_wr;

  // R8
  aen_blocks_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_o |-> !(mem_rd_en_o || mem_wr_en_o || io_rd_en_o || io_wr_en_o));
  // R1
  ready_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aen_o |-> ready_o);
endmodule

// File: tb/cpu_bus_pause_bench.sv
module cpu_bus_pause_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] status = 3'b111;
  logic       req = 1'b0, done = 1'b0;
  logic       ale, rdy, aen, gnt, mrd, mwr, ird, iwr;
  logic       ale_l, rdy_l, aen_l, gnt_l, mrd_l, mwr_l, ird_l, iwr_l;
  int         checks = 0, errors = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  cpu_bus_pause #(.LATER_MODE(1'b0)) u_cpu_bus_pause (
    .clk_i(clk), .rst_ni(rst_n), .status_i(status), .dma_req_i(req),
    .dma_done_i(done), .ale_o(ale), .ready_o(rdy), .aen_o(aen),
    .dma_grant_o(gnt), .mem_rd_en_o(mrd), .mem_wr_en_o(mwr),
    .io_rd_en_o(ird), .io_wr_en_o(iwr));

  cpu_bus_pause #(.LATER_MODE(1'b1)) u_cpu_bus_pause_late (
    .clk_i(clk), .rst_ni(rst_n), .status_i(status), .dma_req_i(req),
    .dma_done_i(done), .ale_o(ale_l), .ready_o(rdy_l), .aen_o(aen_l),
    .dma_grant_o(gnt_l), .mem_rd_en_o(mrd_l), .mem_wr_en_o(mwr_l),
    .io_rd_en_o(ird_l), .io_wr_en_o(iwr_l));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [3:0] exp_cmd(input logic [2:0] s);
    case (s)
      3'b100, 3'b101: return 4'b1000;
      3'b110:         return 4'b0100;
      3'b001:         return 4'b0010;
      3'b010:         return 4'b0001;
      default:        return 4'b0000;
    endcase
  endfunction

  task automatic t_reset();
    chk("R1 reset ale/ready/aen/grant", {ale, rdy, aen, gnt}, 4'b0100);
    rst_n = 1'b1;
    tick();
    chk("R1 after release", {ale, rdy, aen, gnt}, 4'b0100);
  endtask

  task automatic t_ale();
    status = 3'b111; tick();
    status = 3'b101; tick();
    chk("R2 ale pulse on passive->memrd", ale, 1);
    tick();
    chk("R2 ale lasts one cycle", ale, 0);
    status = 3'b110; tick();
    chk("R3 no ale active->active", ale, 0);
    status = 3'b111; tick();
    chk("R3 no ale back to passive", ale, 0);
    tick();
    chk("R3 no ale steady passive", ale, 0);
    status = 3'b001; tick();
    chk("R2 ale pulse on passive->iord", ale, 1);
    status = 3'b111; tick();
  endtask

  task automatic t_cmd();
    for (int s = 0; s < 8; s++) begin
      status = 3'(s);
      #1;
      chk($sformatf("R9 decode code %0d", s), {mrd, mwr, ird, iwr}, exp_cmd(3'(s)));
    end
    status = 3'b111; tick();
  endtask

  task automatic t_grant_orig();
    status = 3'b101; req = 1'b1; tick();
    chk("R4 no grant on memrd status", gnt, 0);
    status = 3'b111; tick();
    chk("R6 grant+aen rise, ready still high", {gnt, aen, rdy}, 3'b111);
    tick();
    chk("R6 ready low one clock later", {gnt, aen, rdy}, 3'b110);
    status = 3'b100; tick();
    chk("R8 stray ale with aen high", {ale, aen}, 2'b11);
    chk("R8 commands blocked under aen", {mrd, mwr, ird, iwr}, 4'b0000);
    req = 1'b0; done = 1'b1; tick();
    chk("R7 grant falls on done", {gnt, aen, rdy}, 3'b010);
    done = 1'b0; tick();
    chk("R7 ready rises with aen fall", {gnt, aen, rdy}, 3'b001);
    chk("R9 fetch enables memrd after release", mrd, 1);
    status = 3'b111; tick();
  endtask

  task automatic t_halt();
    status = 3'b011; req = 1'b1; tick();
    chk("R5 original mode refuses halt", gnt, 0);
    chk("R5 later mode grants on halt", {gnt_l, aen_l}, 2'b11);
    req = 1'b0; tick();
    done = 1'b1; tick();
    done = 1'b0; tick();
    chk("R5 later mode released", {gnt_l, aen_l, rdy_l}, 3'b001);
    chk("R4 original still idle", {gnt, aen, rdy}, 3'b001);
    status = 3'b111; tick();
  endtask

  task automatic t_done_idle();
    done = 1'b1; tick(); tick();
    chk("R10 done ignored when idle", {gnt, aen, rdy}, 3'b001);
    done = 1'b0; tick();
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #5;
    t_reset();
    t_ale();
    t_cmd();
    t_grant_orig();
    t_halt();
    t_done_idle();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule